// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches the running calendar time of a real-time clock and raises an alarm when the time reaches a programmed moment. It holds four alarm bytes: minute, hour, day of month and weekday. Each byte carries its own active-low include bit in bit 7, so software can build an alarm such as "every day at 14:30" or "every Tuesday at any hour". Resolution is one minute. The unit compares only when the timekeeper steps to second 00. A matching minute therefore raises the alarm once and does not raise it again for the rest of that minute.

When every included field matches, a sticky flag is set. Software clears the flag by writing 0 to its bit. An interrupt output follows the flag, gated by an enable bit. No month or year is stored, so the farthest an alarm can lie ahead is roughly one month. Software writes and reads the registers through a simple byte port. The control register offsets and bit positions are kept, so existing software can decode them.

Top module: `alarm_match_unit`

## Requirements
- R1: After synchronous reset, `alarm_flag` and `alarm_irq` are 0, each alarm byte (offsets 0x0A..0x0D) reads 0x80 (field excluded), and offsets 0x00 and 0x01 read 0x00.
- R2: A write to offsets 0x0A (minute), 0x0B (hour), 0x0C (day of month) or 0x0D (weekday) stores all 8 bits, and the byte reads back unchanged. Offset 0x00 reads the interrupt enable in bit 1 and 0 elsewhere. Offset 0x01 reads the flag in bit 3 and 0 elsewhere. Unmapped offsets read 0x00.
- R3: An included field (bit 7 = 0) compares BCD bits 6:0 for the minute, bits 5:0 for the hour and the day of month, and bits 2:0 for the weekday against the current time. Bits outside those ranges are ignored.
- R4: A field whose bit 7 is 1 takes no part in the match. A mismatch in that field does not stop the alarm.
- R5: When all four fields have bit 7 = 1, no match is ever produced.
- R6: Matching is evaluated only in a cycle with `time_tick` = 1 and `cur_sec` = 0x00. A time that matches at any other second leaves the flag unchanged.
- R7: The flag is sticky. Writing offset 0x01 with bit 3 = 0 clears it. Writing bit 3 = 1 leaves it unchanged.
- R8: If a match and a clearing write occur in the same cycle, the flag is set.
- R9: `alarm_irq` is 1 exactly while the flag is 1 and the enable (offset 0x00 bit 1) is 1, and it stays 1 for as long as both remain 1.
- R10: The flag is set on a match whether or not the interrupt is enabled.
- R11: A mismatch in any one included field prevents the flag from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_tick | input | 1 | Timekeeper has presented a new time value this cycle |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD, 24-hour |
| cur_date | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt, flag AND enable |

## Verification
A register write takes effect at the clock edge that samples it. Its read-back appears combinationally right after that edge. The flag changes at the edge that samples `time_tick` with second 00, and the interrupt follows in the same cycle because it is a gate on two registers. The bench therefore drives every input on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge, so each check lands one register stage after its stimulus. A single test case drives a clearing write and a match into the same cycle to pin down which one takes priority.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned N_FIELDS = 4;

    localparam int unsigned SEC_W  = 7;
    localparam int unsigned MIN_W  = 7;
    localparam int unsigned HOUR_W = 6;
    localparam int unsigned DATE_W = 6;
    localparam int unsigned WDAY_W = 3;
    localparam int unsigned VAL_W  = REG_W - 1;

    localparam logic [ADDR_W-1:0] ADR_CTRL_A   = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_CTRL_B   = 5'h01;
    localparam logic [ADDR_W-1:0] ADR_ALM_BASE = 5'h0A;

    localparam int unsigned BIT_AIE  = 1;
    localparam int unsigned BIT_FLAG = 3;
    localparam int unsigned BIT_EXCL = REG_W - 1;

    localparam logic [REG_W-1:0] ALM_RST = 8'h80;

    typedef enum logic [1:0] {
        FLD_MIN  = 2'd0,
        FLD_HOUR = 2'd1,
        FLD_DATE = 2'd2,
        FLD_WDAY = 2'd3
    } field_e;

    typedef struct packed {
        logic [MIN_W-1:0]  minute;
        logic [HOUR_W-1:0] hour;
        logic [DATE_W-1:0] date;
        logic [WDAY_W-1:0] wday;
    } cal_time_t;

    // Significant-bit mask for each field slot.
    function automatic logic [VAL_W-1:0] field_mask(input int unsigned idx);
        case (field_e'(idx[1:0]))
            FLD_MIN:  return VAL_W'((1 << MIN_W) - 1);
            FLD_HOUR: return VAL_W'((1 << HOUR_W) - 1);
            FLD_DATE: return VAL_W'((1 << DATE_W) - 1);
            default:  return VAL_W'((1 << WDAY_W) - 1);
        endcase
    endfunction

    // Pick the time field for a slot and zero-extend it.
    function automatic logic [VAL_W-1:0] time_field(input cal_time_t t,
                                                    input int unsigned idx);
        case (field_e'(idx[1:0]))
            FLD_MIN:  return VAL_W'(t.minute);
            FLD_HOUR: return VAL_W'(t.hour);
            FLD_DATE: return VAL_W'(t.date);
            default:  return VAL_W'(t.wday);
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] slot_addr(input int unsigned idx);
        return ADR_ALM_BASE + ADDR_W'(idx);
    endfunction

endpackage

// File: rtl/alm_regfile.sv
module alm_regfile
    import alm_pkg::*;
#(
    parameter int unsigned NF = N_FIELDS,
    parameter int unsigned RW = REG_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [RW-1:0]        wr_data,
    input  logic [AW-1:0]        rd_addr,
    input  logic                 flag_q,
    output logic [NF-1:0][RW-1:0] alm_q,
    output logic                 aie_q,
    output logic                 clr_req,
    output logic [RW-1:0]        rd_data
);

    for (genvar i = 0; i < NF; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                alm_q[i] <= ALM_RST;
            end else if (wr_en && (wr_addr == slot_addr(i))) begin
                alm_q[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aie_q <= 1'b0;
        end else if (wr_en && (wr_addr == ADR_CTRL_A)) begin
            aie_q <= wr_data[BIT_AIE];
        end
    end

    assign clr_req = wr_en && (wr_addr == ADR_CTRL_B) && !wr_data[BIT_FLAG];

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADR_CTRL_A) begin
            rd_data[BIT_AIE] = aie_q;
        end else if (rd_addr == ADR_CTRL_B) begin
            rd_data[BIT_FLAG] = flag_q;
        end else begin
            for (int i = 0; i < NF; i++) begin
                if (rd_addr == slot_addr(i)) rd_data = alm_q[i];
            end
        end
    end

endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp
    import alm_pkg::*;
#(
    parameter int unsigned NF = N_FIELDS,
    parameter int unsigned RW = REG_W
) (
    input  logic [NF-1:0][RW-1:0] alm_q,
    input  cal_time_t             now,
    output logic [NF-1:0]         fld_en,
    output logic                  match
);

    localparam int unsigned VW = RW - 1;

    logic [NF-1:0] fld_hit;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        logic [VW-1:0] want;
        logic [VW-1:0] have;
        assign want       = alm_q[i][VW-1:0] & field_mask(i);
        assign have       = time_field(now, i) & field_mask(i);
        assign fld_en[i]  = ~alm_q[i][RW-1];
        assign fld_hit[i] = (want == have);
    end

    // At least one included field, and every included field agrees.
    assign match = (|fld_en) && (&(fld_hit | ~fld_en));

endmodule

// File: rtl/alm_flag_ctrl.sv
module alm_flag_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic eval,
    input  logic match,
    input  logic clr_req,
    input  logic aie_q,
    output logic flag_q,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (eval && match) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    assign irq = flag_q & aie_q;

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              time_tick,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [DATE_W-1:0] cur_date,
    input  logic [WDAY_W-1:0] cur_wday,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              alarm_flag,
    output logic              alarm_irq
);

    logic [N_FIELDS-1:0][REG_W-1:0] alm_q;
    logic [N_FIELDS-1:0]            fld_en;
    logic                           aie_q;
    logic                           clr_req;
    logic                           cmp_match;
    logic                           eval;
    cal_time_t                      now;

    assign now  = '{minute: cur_min, hour: cur_hour, date: cur_date, wday: cur_wday};
    assign eval = time_tick && (cur_sec == '0);

    alm_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .flag_q  (alarm_flag),
        .alm_q   (alm_q),
        .aie_q   (aie_q),
        .clr_req (clr_req),
        .rd_data (rd_data)
    );

    alm_field_cmp u_cmp (
        .alm_q  (alm_q),
        .now    (now),
        .fld_en (fld_en),
        .match  (cmp_match)
    );

    alm_flag_ctrl u_flag (
        .clk     (clk),
        .rst     (rst),
        .eval    (eval),
        .match   (cmp_match),
        .clr_req (clr_req),
        .aie_q   (aie_q),
        .flag_q  (alarm_flag),
        .irq     (alarm_irq)
    );

endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk
    import alm_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                eval,
    input logic                match,
    input logic                clr_req,
    input logic                aie_q,
    input logic [N_FIELDS-1:0] fld_en,
    input logic                alarm_flag,
    input logic                alarm_irq
);

    // R6: the flag only rises after an evaluation cycle
    a_r6_rise_needs_eval: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag) |-> $past(eval));

    // R7: the flag holds unless cleared
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !clr_req) |=> alarm_flag);

    // R7: a clearing write without a match drops the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !(eval && match)) |=> !alarm_flag);

    // R8: a match wins over a clear in the same cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (eval && match) |=> alarm_flag);

    // R5: with every field excluded the flag cannot rise
    a_r5_all_excluded: assert property (@(posedge clk) disable iff (rst)
        (fld_en == '0 && !alarm_flag) |=> !alarm_flag);

    // R9: the interrupt tracks flag and enable
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
        alarm_irq == (alarm_flag && aie_q));

endmodule

bind alarm_match_unit alarm_match_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .eval       (eval),
    .match      (cmp_match),
    .clr_req    (clr_req),
    .aie_q      (aie_q),
    .fld_en     (fld_en),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq)
);

// File: tb/alarm_match_unit_bench.sv
module alarm_match_unit_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       time_tick;
    logic [6:0] cur_sec;
    logic [6:0] cur_min;
    logic [5:0] cur_hour;
    logic [5:0] cur_date;
    logic [2:0] cur_wday;
    logic       wr_en;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;
    logic [4:0] rd_addr;
    logic [7:0] rd_data;
    logic       alarm_flag;
    logic       alarm_irq;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    alarm_match_unit u_alarm_match_unit (
        .clk        (clk),
        .rst        (rst),
        .time_tick  (time_tick),
        .cur_sec    (cur_sec),
        .cur_min    (cur_min),
        .cur_hour   (cur_hour),
        .cur_date   (cur_date),
        .cur_wday   (cur_wday),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .alarm_flag (alarm_flag),
        .alarm_irq  (alarm_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic tick(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                        input logic [5:0] dt, input logic [2:0] w);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = dt; cur_wday = w;
        time_tick = 1'b1;
        @(negedge clk);
        time_tick = 1'b0;
    endtask

    task automatic prog(input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] dt, input logic [7:0] w);
        wr(5'h0A, m); wr(5'h0B, h); wr(5'h0C, dt); wr(5'h0D, w);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 flag after reset", alarm_flag, 0);
        chk("R1 irq after reset", alarm_irq, 0);
        rd(5'h0A, v); chk("R1 minute byte reset", v, 8'h80);
        rd(5'h0D, v); chk("R1 weekday byte reset", v, 8'h80);
        rd(5'h00, v); chk("R1 ctrl A reset", v, 8'h00);
        rd(5'h01, v); chk("R1 ctrl B reset", v, 8'h00);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr(5'h0A, 8'h25); rd(5'h0A, v); chk("R2 minute readback", v, 8'h25);
        wr(5'h0D, 8'h83); rd(5'h0D, v); chk("R2 weekday readback", v, 8'h83);
        wr(5'h00, 8'hFF); rd(5'h00, v); chk("R2 ctrl A shows only enable", v, 8'h02);
        rd(5'h05, v); chk("R2 unmapped offset", v, 8'h00);
        wr(5'h00, 8'h00);
    endtask

    task automatic t_full_match;
        logic [7:0] v;
        prog(8'h30, 8'h14, 8'h21, 8'h03);
        tick(7'h00, 7'h30, 6'h14, 6'h21, 3'd3);
        chk("R3 all fields match", alarm_flag, 1);
        chk("R10 flag set with irq disabled, irq low", alarm_irq, 0);
        rd(5'h01, v); chk("R2 ctrl B shows flag", v, 8'h08);
        wr(5'h01, 8'h00);
        chk("R7 clear by writing 0", alarm_flag, 0);
    endtask

    task automatic t_mismatch;
        prog(8'h30, 8'h14, 8'h21, 8'h03);
        tick(7'h00, 7'h30, 6'h15, 6'h21, 3'd3);
        chk("R11 hour mismatch blocks", alarm_flag, 0);
        tick(7'h00, 7'h30, 6'h14, 6'h21, 3'd4);
        chk("R11 weekday mismatch blocks", alarm_flag, 0);
        tick(7'h15, 7'h30, 6'h14, 6'h21, 3'd3);
        chk("R6 nonzero second ignored", alarm_flag, 0);
        @(negedge clk);
        cur_sec = 7'h00; time_tick = 1'b0;
        @(negedge clk);
        chk("R6 no tick no evaluation", alarm_flag, 0);
    endtask

    task automatic t_ignore_field;
        prog(8'h30, 8'h8A, 8'h21, 8'h03);
        tick(7'h00, 7'h30, 6'h07, 6'h21, 3'd3);
        chk("R4 excluded hour ignored", alarm_flag, 1);
        wr(5'h01, 8'h00);
    endtask

    task automatic t_width_mask;
        logic [7:0] v;
        prog(8'h30, 8'h54, 8'h21, 8'h0B);
        rd(5'h0B, v); chk("R2 hour stores all bits", v, 8'h54);
        tick(7'h00, 7'h30, 6'h14, 6'h21, 3'd3);
        chk("R3 bits outside field ignored", alarm_flag, 1);
        wr(5'h01, 8'h00);
    endtask

    task automatic t_all_off;
        prog(8'hB0, 8'h94, 8'hA1, 8'h83);
        tick(7'h00, 7'h30, 6'h14, 6'h21, 3'd3);
        chk("R5 all excluded no match", alarm_flag, 0);
        tick(7'h00, 7'h00, 6'h00, 6'h00, 3'd0);
        chk("R5 all excluded other time", alarm_flag, 0);
    endtask

    task automatic t_sticky;
        prog(8'h05, 8'h80, 8'h80, 8'h80);
        tick(7'h00, 7'h05, 6'h09, 6'h01, 3'd1);
        chk("R3 minute-only match", alarm_flag, 1);
        wr(5'h01, 8'h08);
        chk("R7 writing 1 keeps flag", alarm_flag, 1);
        tick(7'h00, 7'h06, 6'h09, 6'h01, 3'd1);
        chk("R7 flag sticky past match", alarm_flag, 1);
        wr(5'h01, 8'h00);
        chk("R7 cleared", alarm_flag, 0);
    endtask

    task automatic t_irq;
        wr(5'h00, 8'h02);
        chk("R9 enable alone no irq", alarm_irq, 0);
        tick(7'h00, 7'h05, 6'h00, 6'h00, 3'd0);
        chk("R9 irq with flag and enable", alarm_irq, 1);
        repeat (5) @(negedge clk);
        chk("R9 irq stays high", alarm_irq, 1);
        wr(5'h00, 8'h00);
        chk("R9 irq drops with enable", alarm_irq, 0);
        chk("R9 flag unaffected by enable", alarm_flag, 1);
        wr(5'h00, 8'h02);
        chk("R9 irq returns", alarm_irq, 1);
        wr(5'h01, 8'h00);
        chk("R9 irq drops with flag", alarm_irq, 0);
    endtask

    task automatic t_collide;
        tick(7'h00, 7'h05, 6'h00, 6'h00, 3'd0);
        @(negedge clk);
        cur_sec = 7'h00; cur_min = 7'h05; time_tick = 1'b1;
        wr_en = 1'b1; wr_addr = 5'h01; wr_data = 8'h00;
        @(negedge clk);
        time_tick = 1'b0; wr_en = 1'b0;
        chk("R8 match beats clear", alarm_flag, 1);
        wr(5'h01, 8'h00);
        chk("R8 later clear works", alarm_flag, 0);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; time_tick = 1'b0; cur_sec = '0; cur_min = '0; cur_hour = '0;
        cur_date = '0; cur_wday = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_regs;
        t_full_match;
        t_mismatch;
        t_ignore_field;
        t_width_mask;
        t_all_off;
        t_sticky;
        t_irq;
        t_collide;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule